// File: doc/BRIEF.md
# Baseband Digital Gain Loop

This block multiplies each complex baseband sample (I and Q) by an unsigned 16-bit gain and saturates the result to the output width. It also adjusts that gain so the output is as large as possible without clipping. The gain is fixed-point with 12 fractional bits, so 0x1000 is unity, 0x0000 is the minimum and 0xFFFF (just under 16x) is the maximum.

The gain moves only at the end of a measurement window of `WIN_LEN` accepted samples. A two-bit mode input picks the policy. In open mode the gain holds. In the local loop, a window that contained any clipped I or Q sample lowers the gain by a sixteenth, and a window with no clipping raises it by a small fixed step. In the external loop a downstream module drives a single pin: high asks for less gain and low asks for more. A configuration write loads a starting gain at any time, and the gain in use can always be read back.

Top module: `bb_agc`

## Requirements
- R1: After reset `out_valid` is 0 and `gain_out` equals the parameter `INIT_GAIN` (default 0x1000).
- R2: For each accepted sample (`in_valid`=1), one clock later `out_valid` is 1 and each output is floor(in × gain / 4096), with inputs as signed two's complement. `out_valid` is 0 one clock after a cycle without `in_valid`.
- R3: A scaled value above 2^(OW-1)-1 is output as 2^(OW-1)-1, and one below -2^(OW-1) is output as -2^(OW-1). Such a saturation counts as a clip. With the default OW=12 the limits are 2047 and -2048.
- R4: Mode encoding on `mode`: 0 = open loop, 1 = local loop, 2 = external loop, 3 = reserved. In modes 0 and 3 the gain never changes except through a configuration write.
- R5: A window closes on the `WIN_LEN`-th accepted sample counted from reset, from the end of the previous window, or from a configuration write. The gain changes only on the clock edge that accepts that closing sample, or on a configuration write.
- R6: In local mode, a window in which any I or Q sample clipped lowers the gain by max(gain>>4, 1), stopping at 0.
- R7: In local mode, a window with no clip raises the gain by `UP_STEP` (default 32), stopping at 0xFFFF.
- R8: In external mode, `agc_in` is synchronized through two flops and read when the window closes. A value of 1 gives the step down of R6 and a value of 0 gives the step up of R7. Output clipping is ignored in this mode.
- R9: A pulse on `cfg_gain_wr` loads `cfg_gain` into the gain on the next edge in every mode. It takes priority over a window update in the same cycle. It also restarts the window, and a sample accepted in that same cycle is not counted.
- R10: `gain_out` always shows the gain applied to the next accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Loop policy select |
| cfg_gain | input | 16 | Starting gain value |
| cfg_gain_wr | input | 1 | Load strobe for `cfg_gain` |
| agc_in | input | 1 | Gain request pin from a downstream module (1 = lower) |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DW | In-phase input sample, signed |
| in_q | input | DW | Quadrature input sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | OW | Scaled in-phase sample, signed |
| out_q | output | OW | Scaled quadrature sample, signed |
| gain_out | output | 16 | Current gain readback |

## Verification
The loop update that closes a window and a configuration write can land on the same clock edge. In that case the write must win and the window must start over. The bench provokes this by asserting the write together with the closing sample of a local-mode window. It then requires the readback to equal the written value rather than a stepped one. It also requires that one window length of clean samples passes before the next upward step appears. A second test issues a write in the middle of a window and checks that the step arrives a full window after the write, not at the old boundary.

// File: rtl/bb_agc_pkg.sv
package bb_agc_pkg;
  localparam int GAIN_W = 16;
  localparam int GAIN_FRAC = 12;

  typedef enum logic [1:0] {
    MODE_OPEN  = 2'd0,
    MODE_LOCAL = 2'd1,
    MODE_EXT   = 2'd2,
    MODE_RSVD  = 2'd3
  } agc_mode_e;
endpackage

// File: rtl/bb_agc_scaler.sv
module bb_agc_scaler
  import bb_agc_pkg::*;
#(
  parameter int DW = 12,
  parameter int OW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_i,
  input  logic [DW-1:0]     in_q,
  input  logic [GAIN_W-1:0] gain,
  output logic              clip_now,
  output logic              out_valid,
  output logic [OW-1:0]     out_i,
  output logic [OW-1:0]     out_q
);
  localparam int PW = DW + GAIN_W + 1;
  localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (OW-1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  // returns {clip, value}
  function automatic logic [OW:0] scale_sat(input logic [DW-1:0] x,
                                            input logic [GAIN_W-1:0] g);
    logic signed [PW-1:0] xa, ga, p, s;
    xa = {{(PW-DW){x[DW-1]}}, x};
    ga = {{(PW-GAIN_W){1'b0}}, g};
    p  = xa * ga;
    s  = p >>> GAIN_FRAC;
    if (s > MAXV)      return {1'b1, MAXV[OW-1:0]};
    else if (s < MINV) return {1'b1, MINV[OW-1:0]};
    else               return {1'b0, s[OW-1:0]};
  endfunction

  logic [OW:0] res_i, res_q;
  assign res_i    = scale_sat(in_i, gain);
  assign res_q    = scale_sat(in_q, gain);
  assign clip_now = in_valid && (res_i[OW] || res_q[OW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= res_i[OW-1:0];
        out_q <= res_q[OW-1:0];
      end
    end
  end

  AST_CLIP_FULLSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    clip_now |=> (out_i == MAXV[OW-1:0] || out_i == MINV[OW-1:0] ||
                  out_q == MAXV[OW-1:0] || out_q == MINV[OW-1:0])); // R3
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
endmodule

// File: rtl/bb_agc_window.sv
module bb_agc_window #(
  parameter int WIN_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_valid,
  input  logic clip_now,
  input  logic restart,
  output logic win_end,
  output logic clip_hit
);
  localparam int CW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_LEN - 1);

  logic [CW-1:0] cnt;
  logic          clip_acc;

  assign win_end  = sample_valid && (cnt == LAST);
  assign clip_hit = clip_acc || clip_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      clip_acc <= 1'b0;
    end else if (restart || win_end) begin
      cnt      <= '0;
      clip_acc <= 1'b0;
    end else if (sample_valid) begin
      cnt      <= cnt + CW'(1);
      clip_acc <= clip_hit;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R5
  AST_WIN_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end || restart) |=> (cnt == '0 && !clip_acc)); // R5
endmodule

// File: rtl/bb_agc_gain_ctrl.sv
module bb_agc_gain_ctrl
  import bb_agc_pkg::*;
#(
  parameter logic [GAIN_W-1:0] INIT_GAIN = 16'h1000,
  parameter int                UP_STEP   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [GAIN_W-1:0] cfg_gain,
  input  logic              cfg_gain_wr,
  input  logic              agc_in,
  input  logic              win_end,
  input  logic              clip_hit,
  output logic [GAIN_W-1:0] gain
);
  function automatic logic [GAIN_W-1:0] step_down(input logic [GAIN_W-1:0] g);
    logic [GAIN_W-1:0] d;
    d = g >> 4;
    if (d == '0) d = GAIN_W'(1);
    return (g <= d) ? '0 : g - d;
  endfunction

  function automatic logic [GAIN_W-1:0] step_up(input logic [GAIN_W-1:0] g);
    logic [GAIN_W:0] s;
    s = {1'b0, g} + (GAIN_W+1)'(UP_STEP);
    return s[GAIN_W] ? {GAIN_W{1'b1}} : s[GAIN_W-1:0];
  endfunction

  logic [1:0] agc_sync;
  logic       want_down;
  logic       loop_on;
  agc_mode_e  mode_e;

  assign mode_e    = agc_mode_e'(mode);
  assign loop_on   = (mode_e == MODE_LOCAL) || (mode_e == MODE_EXT);
  assign want_down = (mode_e == MODE_EXT) ? agc_sync[1] : clip_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) agc_sync <= 2'b00;
    else        agc_sync <= {agc_sync[0], agc_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gain <= INIT_GAIN;
    else if (cfg_gain_wr)        gain <= cfg_gain;
    else if (win_end && loop_on) gain <= want_down ? step_down(gain) : step_up(gain);
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_gain_wr |=> gain == $past(cfg_gain)); // R9
  AST_HOLD_MIDWINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_gain_wr && !win_end) |=> $stable(gain)); // R5
  AST_OPEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_gain_wr && (mode == 2'd0 || mode == 2'd3)) |=> $stable(gain)); // R4
  AST_LOCAL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_gain_wr && win_end && mode == 2'd1 && clip_hit && gain != '0)
      |=> gain < $past(gain)); // R6
  AST_LOCAL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_gain_wr && win_end && mode == 2'd1 && !clip_hit && gain != '1)
      |=> gain > $past(gain)); // R7
  AST_EXT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_gain_wr && win_end && mode == 2'd2 && agc_sync[1] && gain != '0)
      |=> gain < $past(gain)); // R8
endmodule

// File: rtl/bb_agc.sv
module bb_agc
  import bb_agc_pkg::*;
#(
  parameter int                DW        = 12,
  parameter int                OW        = 12,
  parameter int                WIN_LEN   = 1024,
  parameter int                UP_STEP   = 32,
  parameter logic [GAIN_W-1:0] INIT_GAIN = 16'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [GAIN_W-1:0] cfg_gain,
  input  logic              cfg_gain_wr,
  input  logic              agc_in,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_i,
  input  logic [DW-1:0]     in_q,
  output logic              out_valid,
  output logic [OW-1:0]     out_i,
  output logic [OW-1:0]     out_q,
  output logic [GAIN_W-1:0] gain_out
);
  logic [GAIN_W-1:0] gain;
  logic              clip_now;
  logic              win_end;
  logic              clip_hit;

  bb_agc_scaler #(.DW(DW), .OW(OW)) u_scaler (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_i     (in_i),
    .in_q     (in_q),
    .gain     (gain),
    .clip_now (clip_now),
    .out_valid(out_valid),
    .out_i    (out_i),
    .out_q    (out_q)
  );

  bb_agc_window #(.WIN_LEN(WIN_LEN)) u_window (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_valid(in_valid),
    .clip_now    (clip_now),
    .restart     (cfg_gain_wr),
    .win_end     (win_end),
    .clip_hit    (clip_hit)
  );

  bb_agc_gain_ctrl #(.INIT_GAIN(INIT_GAIN), .UP_STEP(UP_STEP)) u_gain (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .cfg_gain   (cfg_gain),
    .cfg_gain_wr(cfg_gain_wr),
    .agc_in     (agc_in),
    .win_end    (win_end),
    .clip_hit   (clip_hit),
    .gain       (gain)
  );

  assign gain_out = gain;

  AST_READBACK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_gain_wr && !in_valid) |=> $stable(gain_out)); // R10
endmodule

// File: tb/bb_agc_tb.sv
module bb_agc_tb;
  localparam int DW = 12;
  localparam int OW = 12;
  localparam int WL = 32;
  localparam int UP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [15:0] cfg_gain = 16'h0;
  logic cfg_gain_wr = 1'b0;
  logic agc_in = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_i = '0;
  logic [DW-1:0] in_q = '0;
  logic out_valid;
  logic [OW-1:0] out_i, out_q;
  logic [15:0] gain_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bb_agc #(.DW(DW), .OW(OW), .WIN_LEN(WL), .UP_STEP(UP), .INIT_GAIN(16'h1000)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cfg_gain(cfg_gain),
    .cfg_gain_wr(cfg_gain_wr), .agc_in(agc_in), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i),
    .out_q(out_q), .gain_out(gain_out)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_scale(int x, int g);
    longint p;
    p = longint'(x) * longint'(g);
    p = p >>> 12;
    if (p > 2047) p = 2047;
    if (p < -2048) p = -2048;
    return int'(p);
  endfunction

  function automatic int dn(int g);
    int d;
    d = g / 16;
    if (d == 0) d = 1;
    return (g <= d) ? 0 : g - d;
  endfunction

  function automatic int upg(int g);
    return (g + UP > 65535) ? 65535 : g + UP;
  endfunction

  task automatic load(int g);
    cfg_gain = 16'(g);
    cfg_gain_wr = 1'b1;
    tick();
    cfg_gain_wr = 1'b0;
  endtask

  task automatic send(int xi, int xq);
    in_valid = 1'b1;
    in_i = DW'(xi);
    in_q = DW'(xq);
    tick();
    in_valid = 1'b0;
  endtask

  task automatic send_n(int n, int xi, int xq);
    for (int k = 0; k < n; k++) send(xi, xq);
  endtask

  task automatic t_reset();
    check("R1 out_valid", out_valid, 0);
    check("R1 gain", gain_out, 16'h1000);
  endtask

  task automatic t_scale();
    mode = 2'd0;
    load(16'h1800);
    send(100, -3);
    check("R2 out_valid", out_valid, 1);
    check("R2 i", $signed(out_i), exp_scale(100, 16'h1800));
    check("R2 q", $signed(out_q), exp_scale(-3, 16'h1800));
    load(16'h0800);
    send(-1, 777);
    check("R2 i floor", $signed(out_i), -1);
    check("R2 q", $signed(out_q), exp_scale(777, 16'h0800));
    tick();
    check("R2 valid drop", out_valid, 0);
  endtask

  task automatic t_sat();
    mode = 2'd0;
    load(16'h4000);
    send(1000, -1000);
    check("R3 high", $signed(out_i), 2047);
    check("R3 low", $signed(out_q), -2048);
    send(511, -512);
    check("R3 edge i", $signed(out_i), 2044);
    check("R3 edge q", $signed(out_q), -2048);
  endtask

  task automatic t_open();
    mode = 2'd0;
    load(16'h4000);
    send_n(WL * 2, 1000, 1000);
    check("R4 open hold", gain_out, 16'h4000);
    mode = 2'd3;
    send_n(WL, 0, 0);
    check("R4 reserved hold", gain_out, 16'h4000);
  endtask

  task automatic t_local();
    mode = 2'd1;
    load(16'h4000);
    send_n(WL - 2, 0, 0);
    send(0, 900);
    check("R5 no mid change", gain_out, 16'h4000);
    send(0, 0);
    check("R6 step down", gain_out, dn(16'h4000));
    load(16'h1000);
    send_n(WL, 10, -10);
    check("R7 step up", gain_out, upg(16'h1000));
    load(16'hFFF0);
    send_n(WL, 0, 0);
    check("R7 clamp top", gain_out, 16'hFFFF);
  endtask

  task automatic t_ext();
    mode = 2'd2;
    agc_in = 1'b1;
    load(16'h2000);
    tick(); tick();
    send_n(WL, 0, 0);
    check("R8 pin high down", gain_out, dn(16'h2000));
    agc_in = 1'b0;
    tick(); tick();
    load(16'h4000);
    send_n(WL, 1000, 1000);
    check("R8 clip ignored up", gain_out, upg(16'h4000));
    agc_in = 1'b1;
    load(1);
    tick(); tick();
    send_n(WL, 0, 0);
    check("R6 floor", gain_out, 0);
    send_n(WL, 0, 0);
    check("R6 stay zero", gain_out, 0);
    agc_in = 1'b0;
  endtask

  task automatic t_collide();
    mode = 2'd1;
    load(16'h1000);
    send_n(WL - 1, 0, 0);
    cfg_gain = 16'h0500;
    cfg_gain_wr = 1'b1;
    send(0, 0);
    cfg_gain_wr = 1'b0;
    check("R9 write wins", gain_out, 16'h0500);
    send_n(WL - 1, 0, 0);
    check("R9 window restarted", gain_out, 16'h0500);
    send(0, 0);
    check("R10 readback step", gain_out, upg(16'h0500));
    send(100, 0);
    check("R10 gain applied", $signed(out_i), exp_scale(100, upg(16'h0500)));
  endtask

  task automatic t_midload();
    mode = 2'd1;
    load(16'h1000);
    send_n(10, 0, 0);
    load(16'h0800);
    send_n(WL - 1, 0, 0);
    check("R9 mid write restart", gain_out, 16'h0800);
    send(0, 0);
    check("R9 step after full window", gain_out, upg(16'h0800));
  endtask

  initial begin
    tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_scale();
    t_sat();
    t_open();
    t_local();
    t_ext();
    t_collide();
    t_midload();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule